// File: doc/BRIEF.md
# Tick-Driven Multi-Output Pulse Width Modulator

This block makes pulse-width-modulated waveforms from one shared up-counter. The counter advances once for every pulse on a prescaled tick input. When it reaches the period value it returns to zero, so one period lasts (period + 1) ticks. A bank of compare values sets the edges of each output. An output in single-edge mode rises when the period restarts and falls at its compare value. An output in dual-edge mode takes its rising edge and its falling edge from two separate compare values. If the falling value is the lower of the two, the pulse is negative. Every output has its own mode, so positive and negative pulses can run side by side. The three outputs of the default build are enough for three-phase motor drive.

Software writes through a simple write port. Period values, compare values and output modes go into shadow copies first. They reach the active set only at the tick where the counter wraps, so a reprogrammed waveform never produces a partial pulse. When the counter equals any compare value whose interrupt is enabled, the block raises a one-cycle interrupt pulse.

Top module: `tick_pwm`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bit of `pwm_o` is 0 and `irq_o` is 0. Reset clears all shadow and active values to 0.
- R2: The counter advances by one only on a clock edge where `tick_i` is 1. On such an edge, if the counter equals the active period value, it returns to 0 instead. With `tick_i` low, all outputs hold steady.
- R3: The write map is as follows. Address 0 holds the period. Address 2c+1 holds the rise compare of output c, and address 2c+2 holds its fall compare. Address 2N+1 holds the mode bits (bit c = 1 puts output c in dual-edge mode). Address 2N+2 holds the interrupt enables. The period, compare and mode values are shadowed and copied to the active set only on a wrap edge. Writes to any address above 2N+2 change nothing.
- R4: Single-edge output c is 1 exactly while the count is below its fall compare. Its rise compare is not used.
- R5: A dual-edge output whose rise compare is less than or equal to its fall compare is 1 exactly while rise ≤ count < fall. Equal values give a constant 0.
- R6: A dual-edge output whose fall compare is below its rise compare gives a negative pulse. The output is 1 while count < fall or count ≥ rise.
- R7: A compare value above the period gives a constant level. For example, a single-edge output whose fall compare exceeds the period stays at 1.
- R8: Interrupt enable bit 0 belongs to the period value, and bit k belongs to the compare at address k. `irq_o` is 1 for one cycle after an edge where `tick_i` is 1 and the count equals an enabled value. A new enable mask acts from the edge after the write.
- R9: The outputs are independent. Positive pulses, negative pulses and single-edge waveforms can appear on different outputs during the same period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaled count enable, one pulse per counter step |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | CW | Write data |
| pwm_o | output | NCH | PWM outputs, one bit per output |
| irq_o | output | 1 | One-cycle interrupt pulse on an enabled match |

## Verification
Both `pwm_o` and `irq_o` come from registers. In the cycle after a clock edge they reflect the count and the active values held just before that edge. A wrap or a write therefore changes the output waveform one edge later than it changes the counter state. The bench updates its model at each edge using the values from before the edge. It compares the outputs at the following falling edge, which is exactly one register stage after the stimulus.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic {
        EDGE_SINGLE = 1'b0,
        EDGE_DUAL   = 1'b1
    } edge_mode_e;

    // Output level for a given count and compare pair.
    function automatic logic edge_level(edge_mode_e mode, int unsigned cnt,
                                        int unsigned rise, int unsigned fall);
        if (mode == EDGE_SINGLE) begin
            return cnt < fall;
        end
        if (rise <= fall) begin
            return (cnt >= rise) && (cnt < fall);
        end
        return (cnt < fall) || (cnt >= rise);
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == period_i);
        if (tick_i) begin
            st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = tick_i && at_end;

endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
    parameter int CW  = 16,
    parameter int NCH = 3,
    parameter int NM  = 2 * NCH + 1,
    parameter int AW  = $clog2(2 * NCH + 3)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [AW-1:0]          wr_addr_i,
    input  logic [CW-1:0]          wr_data_i,
    input  logic                   wrap_i,
    output logic [NM-1:0][CW-1:0]  act_match_o,
    output logic [NCH-1:0]         act_mode_o,
    output logic [NM-1:0]          irq_en_o
);

    localparam int ADDR_MODE = NM;
    localparam int ADDR_EN   = NM + 1;

    typedef struct packed {
        logic [NM-1:0][CW-1:0] shd;
        logic [NM-1:0][CW-1:0] act;
        logic [NCH-1:0]        shd_mode;
        logic [NCH-1:0]        act_mode;
        logic [NM-1:0]         en;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (wrap_i) begin
            bk_d.act      = bk_q.shd;
            bk_d.act_mode = bk_q.shd_mode;
        end
        if (wr_en_i) begin
            for (int k = 0; k < NM; k++) begin
                if (32'(wr_addr_i) == k) begin
                    bk_d.shd[k] = wr_data_i;
                end
            end
            if (32'(wr_addr_i) == ADDR_MODE) begin
                bk_d.shd_mode = wr_data_i[NCH-1:0];
            end
            if (32'(wr_addr_i) == ADDR_EN) begin
                bk_d.en = wr_data_i[NM-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign act_match_o = bk_q.act;
    assign act_mode_o  = bk_q.act_mode;
    assign irq_en_o    = bk_q.en;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] rise_i,
    input  logic [CW-1:0] fall_i,
    output logic          pwm_o
);

    typedef struct packed {
        logic out;
    } ch_state_t;

    ch_state_t ch_d, ch_q;

    always_comb begin
        ch_d     = ch_q;
        ch_d.out = edge_level(edge_mode_e'(dual_i), 32'(cnt_i),
                              32'(rise_i), 32'(fall_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign pwm_o = ch_q.out;

endmodule

// File: rtl/tick_pwm.sv
module tick_pwm #(
    parameter int CW  = 16,
    parameter int NCH = 3,
    parameter int AW  = $clog2(2 * NCH + 3)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  wr_addr_i,
    input  logic [CW-1:0]  wr_data_i,
    output logic [NCH-1:0] pwm_o,
    output logic           irq_o
);

    localparam int NM = 2 * NCH + 1;

    logic [CW-1:0]         cnt_q;
    logic                  wrap;
    logic [NM-1:0][CW-1:0] act_match;
    logic [NCH-1:0]        act_mode;
    logic [NM-1:0]         irq_en;

    pwm_timebase #(.CW(CW)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .period_i (act_match[0]),
        .cnt_o    (cnt_q),
        .wrap_o   (wrap)
    );

    pwm_match_bank #(.CW(CW), .NCH(NCH), .NM(NM), .AW(AW)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .wrap_i      (wrap),
        .act_match_o (act_match),
        .act_mode_o  (act_mode),
        .irq_en_o    (irq_en)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_channel #(.CW(CW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .dual_i (act_mode[c]),
            .cnt_i  (cnt_q),
            .rise_i (act_match[2*c+1]),
            .fall_i (act_match[2*c+2]),
            .pwm_o  (pwm_o[c])
        );
    end

    typedef struct packed {
        logic irq;
    } top_state_t;

    top_state_t ts_d, ts_q;
    logic [NM-1:0] hit;

    always_comb begin
        ts_d = ts_q;
        for (int k = 0; k < NM; k++) begin
            hit[k] = (cnt_q == act_match[k]);
        end
        ts_d.irq = tick_i && (|(hit & irq_en));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    assign irq_o = ts_q.irq;

endmodule

// File: rtl/tick_pwm_chk.sv
module tick_pwm_chk #(
    parameter int CW  = 16,
    parameter int NCH = 3,
    parameter int NM  = 2 * NCH + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_i,
    input logic                  irq_o,
    input logic [NCH-1:0]        pwm_o,
    input logic [CW-1:0]         cnt,
    input logic                  wrap,
    input logic [NM-1:0][CW-1:0] act_match,
    input logic [NCH-1:0]        act_mode
);

    // R2: counter never passes the active period
    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_match[0]);

    // R2: no tick, no count change
    assert_cnt_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt));

    // R3: active set changes only on a wrap
    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(act_match) && $stable(act_mode)));

    // R8: interrupt only follows a tick
    assert_irq_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(tick_i));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R5: equal dual-edge compares give a low output
        assert_dual_equal_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (act_mode[c] && act_match[2*c+1] == act_match[2*c+2]) |=> !pwm_o[c]);

        // R7: single-edge fall beyond period gives constant high
        assert_single_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!act_mode[c] && act_match[2*c+2] > act_match[0]) |=> pwm_o[c]);
    end

endmodule

bind tick_pwm tick_pwm_chk #(.CW(CW), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .irq_o     (irq_o),
    .pwm_o     (pwm_o),
    .cnt       (cnt_q),
    .wrap      (wrap),
    .act_match (act_match),
    .act_mode  (act_mode)
);

// File: tb/test_tick_pwm.sv
`timescale 1ns/1ps
module test_tick_pwm;

    localparam int CW  = 16;
    localparam int NCH = 3;
    localparam int NM  = 2 * NCH + 1;
    localparam int AW  = $clog2(2 * NCH + 3);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick_i = 1'b0;
    logic           wr_en_i = 1'b0;
    logic [AW-1:0]  wr_addr_i = '0;
    logic [CW-1:0]  wr_data_i = '0;
    logic [NCH-1:0] pwm_o;
    logic           irq_o;

    tick_pwm #(.CW(CW), .NCH(NCH)) i_tick_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .pwm_o     (pwm_o),
        .irq_o     (irq_o)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // bench model of the programmed state
    int unsigned m_shd [NM];
    int unsigned m_act [NM];
    int unsigned m_cnt;
    logic [NCH-1:0] m_smode, m_amode;
    logic [NM-1:0]  m_en;

    function automatic bit exp_level(bit dual, int unsigned cnt,
                                     int unsigned r, int unsigned f);
        if (!dual) return cnt < f;
        if (r <= f) return (r <= cnt) && (cnt < f);
        return !((f <= cnt) && (cnt < r));
    endfunction

    function automatic string auto_tag(int c);
        if (!m_amode[c]) return (m_act[2*c+2] > m_act[0]) ? "R7" : "R4";
        if (m_act[2*c+1] <= m_act[2*c+2]) return "R5";
        return "R6";
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock step starting and ending at a falling edge
    task automatic step(bit tk, bit we, int ad, int dt, string tag);
        bit exp_out [NCH];
        string ctag [NCH];
        bit exp_irq, wr;
        tick_i    = tk;
        wr_en_i   = we;
        wr_addr_i = AW'(ad);
        wr_data_i = CW'(dt);
        exp_irq = 1'b0;
        for (int k = 0; k < NM; k++)
            if (tk && m_en[k] && m_cnt == m_act[k]) exp_irq = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            exp_out[c] = exp_level(m_amode[c], m_cnt, m_act[2*c+1], m_act[2*c+2]);
            ctag[c] = (tag == "") ? auto_tag(c) : tag;
        end
        wr = tk && (m_cnt == m_act[0]);
        if (wr) begin
            for (int k = 0; k < NM; k++) m_act[k] = m_shd[k];
            m_amode = m_smode;
        end
        if (we) begin
            if (ad < NM) m_shd[ad] = dt & 16'hffff;
            else if (ad == NM) m_smode = NCH'(dt);
            else if (ad == NM + 1) m_en = NM'(dt);
        end
        if (tk) m_cnt = wr ? 0 : m_cnt + 1;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) check(ctag[c], int'(pwm_o[c]), int'(exp_out[c]));
        check("R8", int'(irq_o), int'(exp_irq));
    endtask

    initial begin
        #500us;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < NM; k++) begin m_shd[k] = 0; m_act[k] = 0; end
        m_cnt = 0; m_smode = '0; m_amode = '0; m_en = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(pwm_o), 0);
        check("R1", int'(irq_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(pwm_o), 0);
        check("R1", int'(irq_o), 0);

        // directed three-phase set: single, positive dual, negative dual
        step(0, 1, 0, 9, "R3");
        step(0, 1, 2, 4, "R3");
        step(0, 1, 3, 2, "R3");
        step(0, 1, 4, 7, "R3");
        step(0, 1, 5, 7, "R3");
        step(0, 1, 6, 3, "R3");
        step(0, 1, NM, 6, "R3");
        step(0, 1, NM + 1, 5, "R8");
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0, "R9");

        // R2: no ticks, outputs hold
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, "R2");

        // R3: mid-period rewrite and write to unused address
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R3");
        step(1, 1, 2, 8, "R3");
        step(1, 1, NM + 3, 16'hffff, "R3");
        for (int i = 0; i < 25; i++) step(1, 0, 0, 0, "R3");

        // R7 / R5: constant levels
        step(1, 1, 2, 20, "R7");
        step(1, 1, 3, 5, "R5");
        step(1, 1, 4, 5, "R5");
        for (int i = 0; i < 25; i++) step(1, 0, 0, 0, "");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit tk = ($urandom % 10) < 7;
            bit we = ($urandom % 8) == 0;
            int ad = $urandom % 12;
            int dt = (ad == NM || ad == NM + 1) ? int'($urandom % 128) : int'($urandom % 14);
            step(tk, we, ad, dt, "");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule